// File: doc/BRIEF.md
# Multi-Channel Periodic Interrupt Timer

This block is a bus-mapped timer with several independent down-counting channels, four by default, each 32 bits wide. Software programs a reload value for a channel and sets the channel running. The counter steps down once per clock. When it hits zero it reloads, marks a sticky expiry flag and, if the channel's interrupt is unmasked, drives its interrupt line until software clears the flag. One global bit in a module control word freezes every channel at once.

A channel other than channel 0 can be set to cascade from the channel below it. It then steps only on the cycles in which its lower neighbour wraps. This makes two 32-bit channels act as one 64-bit period counter. A new reload value never disturbs a running count. It is used at the next wrap, or when the channel is stopped and started again.

The register interface uses one-cycle write and read strobes, a byte address and a full-width data word. Read data is registered and appears on the cycle after the read strobe.

Top module: `mpit_top`

## Requirements
- R1: After reset, every channel's load value, current value, control and flag are zero, every `irq` bit is low, `rdata` is zero, and the module control word reads 0x2 (module frozen).
- R2: The module control word is at byte address 0x000. Channel n occupies 0x100 + 0x10·n, with load value at +0x0, current value at +0x4, control at +0x8 and flag at +0xC. Read data is captured at the clock edge where `rd_en` is high and is held until the next read.
- R3: Control bit 0 runs the channel, bit 1 unmasks its interrupt and bit 2 selects cascade mode. Writing bit 0 from 0 to 1 copies the load value into the current value at the edge that accepts the write.
- R4: A running channel whose module is not frozen decrements by one per clock. On a clock where its value is zero it reloads from the load value instead, so one period is load + 1 clocks.
- R5: Flag bit 0 is set at each wrap and stays set. Writing 1 to flag bit 0 clears it and writing 0 does nothing. A wrap in the same cycle as a clear leaves the flag set.
- R6: `irq[n]` equals channel n's flag AND its interrupt-unmask bit, as a level.
- R7: Writing the load value of a running channel leaves the current count untouched. The new value is used at the next wrap.
- R8: A stopped channel holds its current value. Writing the run bit as 1 while it is already 1 causes no reload.
- R9: While module control bit 1 is set, no channel decrements, wraps or sets its flag.
- R10: A cascaded channel n > 0 steps only in the cycles in which channel n−1 wraps. The cascade bit of channel 0 has no effect.
- R11: The current value ignores writes. Reads of unmapped or non-word-aligned addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | ADDR_W (12) | Byte address |
| wdata | input | CW (32) | Write data |
| rdata | output | CW (32) | Registered read data |
| irq | output | NCH (4) | Per-channel level interrupt |

## Verification
The embedded properties check the following on every cycle: the flag set at a wrap, flag stickiness and clearing, the reload value after a wrap, the hold of a stopped, cascade-gated or frozen counter, the undisturbed step when a load write lands mid-count, and that read data changes only under a read strobe. Some behaviour shows only over whole scenarios, so the bench covers it: the exact period of load + 1 clocks, the count of a cascaded pair after many low-channel wraps, the deferred use of a new load value, a clear that collides with a wrap, and the address map with its zero reads. The bench freezes the module at a chosen cycle, so each reading corresponds to an exact elapsed count.

// File: rtl/mpit_pkg.sv
package mpit_pkg;

  // Register selector inside one channel's 16-byte window (address bits 3:2)
  typedef enum logic [1:0] {
    RS_LOAD = 2'd0,
    RS_CUR  = 2'd1,
    RS_CTRL = 2'd2,
    RS_FLAG = 2'd3
  } reg_sel_e;

  // Channel control word, bit 0 = run, bit 1 = irq unmask, bit 2 = cascade
  typedef struct packed {
    logic chain;
    logic irq_en;
    logic run;
  } chan_ctl_t;

  localparam int MCR_ADDR    = 'h000;
  localparam int CH_BASE     = 'h100;
  localparam int CH_STRIDE   = 'h10;
  localparam int MCR_DIS_BIT = 1;

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
  import mpit_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 12,
  localparam int CH_IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              mcr_hit,
  output logic              ch_hit,
  output logic [CH_IW-1:0]  ch_idx,
  output reg_sel_e          rsel
);

  localparam logic [ADDR_W-1:0] MCR_A  = ADDR_W'(MCR_ADDR);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(CH_BASE);
  localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(CH_BASE + CH_STRIDE * NCH);

  logic [ADDR_W-1:0] off;

  always_comb begin
    off     = addr - BASE_A;
    mcr_hit = (addr == MCR_A);
    ch_hit  = (addr >= BASE_A) && (addr < END_A) && (addr[1:0] == 2'b00);
    ch_idx  = off[4 +: CH_IW];
    rsel    = reg_sel_e'(off[3:2]);
  end

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import mpit_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          count_ok,
  input  logic          chain_tick,
  input  logic          ld_we,
  input  logic          ctl_we,
  input  logic          flg_we,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] cur,
  output logic [CW-1:0] load,
  output chan_ctl_t     ctl,
  output logic          flag,
  output logic          expire,
  output logic          irq
);

  logic [CW-1:0] cv_q, cv_d, ld_q, ld_d;
  chan_ctl_t     ctl_q, ctl_d, wctl;
  logic          flag_q, flag_d;
  logic          start, tick, at_zero;
  logic          cv_en, ld_en, ctl_en, flag_en;

  // next-state
  always_comb begin
    wctl    = chan_ctl_t'(wdata[2:0]);
    start   = ctl_we && wctl.run && !ctl_q.run;
    tick    = ctl_q.run && count_ok && (!ctl_q.chain || chain_tick);
    at_zero = (cv_q == '0);
    expire  = tick && at_zero;

    ld_d  = wdata;
    ctl_d = wctl;

    cv_d = cv_q;
    if (start)     cv_d = ld_q;
    else if (tick) cv_d = at_zero ? ld_q : cv_q - CW'(1);

    flag_d = expire || (flag_q && !(flg_we && wdata[0]));

    cv_en   = start || tick;
    ld_en   = ld_we;
    ctl_en  = ctl_we;
    flag_en = expire || flg_we;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cv_q   <= '0;
      ld_q   <= '0;
      ctl_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cv_en)   cv_q   <= cv_d;
      if (ld_en)   ld_q   <= ld_d;
      if (ctl_en)  ctl_q  <= ctl_d;
      if (flag_en) flag_q <= flag_d;
    end
  end

  always_comb begin
    cur  = cv_q;
    load = ld_q;
    ctl  = ctl_q;
    flag = flag_q;
    irq  = flag_q && ctl_q.irq_en;
  end

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag_q);
  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flg_we) |=> flag_q);
  // R5
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_we && wdata[0] && !expire) |=> !flag_q);
  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cv_q == $past(ld_q)));
  // R7
  ld_nodisturb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_we && tick && !at_zero) |=> (cv_q == $past(cv_q) - CW'(1)));
  // R8
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.run && !start) |=> $stable(cv_q));
  // R10
  chain_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.run && ctl_q.chain && !chain_tick) |=> $stable(cv_q));
  // R6
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag_q);

endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
  import mpit_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 32,
  localparam int CH_IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                    mcr_hit,
  input  logic                    ch_hit,
  input  logic [CH_IW-1:0]        ch_idx,
  input  reg_sel_e                rsel,
  input  logic                    mdis,
  input  logic [NCH-1:0][CW-1:0]  cur_all,
  input  logic [NCH-1:0][CW-1:0]  load_all,
  input  logic [NCH-1:0][2:0]     ctl_all,
  input  logic [NCH-1:0]          flag_all,
  output logic [CW-1:0]           rd_val
);

  always_comb begin
    rd_val = '0;
    if (mcr_hit) begin
      rd_val[MCR_DIS_BIT] = mdis;
    end else if (ch_hit) begin
      unique case (rsel)
        RS_LOAD: rd_val = load_all[ch_idx];
        RS_CUR:  rd_val = cur_all[ch_idx];
        RS_CTRL: rd_val = CW'(ctl_all[ch_idx]);
        RS_FLAG: rd_val = CW'(flag_all[ch_idx]);
        default: rd_val = '0;
      endcase
    end
  end

endmodule

// File: rtl/mpit_top.sv
module mpit_top
  import mpit_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CW     = 32,
  parameter int ADDR_W = 12,
  localparam int CH_IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CW-1:0]     wdata,
  output logic [CW-1:0]     rdata,
  output logic [NCH-1:0]    irq
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ns   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ns   <= rst_meta;
    end
  end

  logic             mcr_hit, ch_hit;
  logic [CH_IW-1:0] ch_idx;
  reg_sel_e         rsel;

  tmr_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
    .addr    (addr),
    .mcr_hit (mcr_hit),
    .ch_hit  (ch_hit),
    .ch_idx  (ch_idx),
    .rsel    (rsel)
  );

  // module control word
  logic mdis_q, mdis_d, mdis_en;
  always_comb begin
    mdis_en = wr_en && mcr_hit;
    mdis_d  = wdata[MCR_DIS_BIT];
  end
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)      mdis_q <= 1'b1;
    else if (mdis_en) mdis_q <= mdis_d;
  end

  logic [NCH-1:0][CW-1:0] cur_all, load_all;
  logic [NCH-1:0][2:0]    ctl_all;
  logic [NCH-1:0]         flag_all, exp_all;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic      sel, tick_in;
    chan_ctl_t ctl_s;

    assign sel = wr_en && ch_hit && (ch_idx == CH_IW'(i));

    if (i == 0) begin : g_head
      assign tick_in = 1'b1;
    end else begin : g_link
      assign tick_in = exp_all[i-1];
    end

    tmr_chan #(.CW(CW)) u_ch (
      .clk        (clk),
      .rst_n      (rst_ns),
      .count_ok   (!mdis_q),
      .chain_tick (tick_in),
      .ld_we      (sel && (rsel == RS_LOAD)),
      .ctl_we     (sel && (rsel == RS_CTRL)),
      .flg_we     (sel && (rsel == RS_FLAG)),
      .wdata      (wdata),
      .cur        (cur_all[i]),
      .load       (load_all[i]),
      .ctl        (ctl_s),
      .flag       (flag_all[i]),
      .expire     (exp_all[i]),
      .irq        (irq[i])
    );

    assign ctl_all[i] = ctl_s;
  end

  logic [CW-1:0] rd_val, rdata_q;

  tmr_rdmux #(.NCH(NCH), .CW(CW)) u_rd (
    .mcr_hit  (mcr_hit),
    .ch_hit   (ch_hit),
    .ch_idx   (ch_idx),
    .rsel     (rsel),
    .mdis     (mdis_q),
    .cur_all  (cur_all),
    .load_all (load_all),
    .ctl_all  (ctl_all),
    .flag_all (flag_all),
    .rd_val   (rd_val)
  );

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)    rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_val;
  end
  assign rdata = rdata_q;

  // R9
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (mdis_q && !wr_en) |=> $stable(cur_all));
  // R9
  frozen_noflag_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    mdis_q |=> ((flag_all & ~$past(flag_all)) == '0));
  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !rd_en |=> $stable(rdata));

endmodule

// File: tb/mpit_top_tb.sv
`timescale 1ns/1ps
module mpit_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  mpit_top u_dut (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .irq   (irq)
  );

  localparam logic [11:0] A_MCR = 12'h000;
  localparam int O_LD = 0, O_CUR = 4, O_CTL = 8, O_FLG = 12;

  function automatic logic [11:0] ca(int ch, int o);
    return 12'(12'h100 + ch * 16 + o);
  endfunction

  // value after k counting clocks since a start with load L (period L+1)
  function automatic logic [31:0] exp_cur(int unsigned l, int unsigned k);
    return 32'(l - (k % (l + 1)));
  endfunction
  function automatic logic [31:0] exp_flag(int unsigned l, int unsigned k);
    return (k >= l + 1) ? 32'd1 : 32'd0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired got=%0d exp=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int unsigned l0, l1, m, n0;
    void'($urandom(32'd24681));
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 rdata", rdata, 32'd0);
    rd(A_MCR, d);         chk("R1 mcr", d, 32'h2);
    rd(ca(0, O_LD), d);   chk("R1 load", d, 32'd0);
    rd(ca(2, O_CUR), d);  chk("R1 cur", d, 32'd0);
    rd(ca(3, O_CTL), d);  chk("R1 ctrl", d, 32'd0);
    rd(ca(1, O_FLG), d);  chk("R1 flag", d, 32'd0);

    // R11 unmapped / misaligned reads
    rd(12'h004, d); chk("R11 unmapped 0x004", d, 32'd0);
    rd(12'h0FC, d); chk("R11 unmapped 0x0FC", d, 32'd0);
    rd(12'h140, d); chk("R11 unmapped 0x140", d, 32'd0);
    rd(12'h102, d); chk("R11 misaligned 0x102", d, 32'd0);

    // Random single-channel periods, frozen at a chosen cycle (R2 R3 R4 R6 R9 R10)
    for (int it = 0; it < 40; it++) begin
      int ch, ie, chn;
      ch  = $urandom_range(0, 3);
      l0  = $urandom_range(1, 40);
      m   = $urandom_range(1, 100);
      ie  = $urandom_range(0, 1);
      chn = (ch == 0) ? $urandom_range(0, 1) : 0;  // R10 cascade bit of ch0 ignored
      wr(A_MCR, 32'd0);
      wr(ca(ch, O_LD), l0);
      wr(ca(ch, O_CTL), 32'(chn * 4 + ie * 2 + 1));   // start edge E
      idle(int'(m) - 1);
      wr(A_MCR, 32'h2);                               // freeze at edge E+m
      rd(ca(ch, O_CUR), d);  chk("R4 cur after m clocks", d, exp_cur(l0, m));
      rd(ca(ch, O_FLG), d);  chk("R5 flag after m clocks", d, exp_flag(l0, m));
      chk("R6 irq level", 32'(irq[ch]), 32'(ie) & exp_flag(l0, m));
      rd(ca(ch, O_CTL), d);  chk("R3 ctrl readback", d, 32'(chn * 4 + ie * 2 + 1));
      rd(ca(ch, O_LD), d);   chk("R2 load readback", d, l0);
      rd(ca(ch, O_CUR), d);  chk("R9 frozen cur", d, exp_cur(l0, m));
      wr(ca(ch, O_FLG), 32'd1);
      rd(ca(ch, O_FLG), d);  chk("R5 flag cleared", d, 32'd0);
      wr(ca(ch, O_CTL), 32'd0);
    end

    // R10 cascade: ch1 steps once per ch0 wrap
    l0 = 3; l1 = 2;
    m  = $urandom_range(5, 60);
    wr(A_MCR, 32'd0);
    wr(ca(0, O_LD), l0);
    wr(ca(1, O_LD), l1);
    wr(ca(1, O_CTL), 32'h5);        // run + cascade, no low-side ticks yet
    idle(3);
    rd(ca(1, O_CUR), d);  chk("R10 cascaded idle hold", d, l1);
    wr(ca(0, O_CTL), 32'h1);        // edge E
    idle(int'(m) - 1);
    wr(A_MCR, 32'h2);               // edge E+m
    n0 = m / (l0 + 1);
    rd(ca(0, O_CUR), d);  chk("R10 low channel cur", d, exp_cur(l0, m));
    rd(ca(1, O_CUR), d);  chk("R10 cascaded cur", d, exp_cur(l1, n0));
    rd(ca(1, O_FLG), d);  chk("R10 cascaded flag", d, exp_flag(l1, n0));
    wr(ca(0, O_CTL), 32'd0);
    wr(ca(1, O_CTL), 32'd0);
    wr(ca(0, O_FLG), 32'd1);
    wr(ca(1, O_FLG), 32'd1);

    // R5 clear colliding with wrap, write of 0 ignored
    wr(A_MCR, 32'd0);
    wr(ca(0, O_LD), 32'd3);
    wr(ca(0, O_CTL), 32'h3);        // edge E
    idle(3);
    wr(ca(0, O_FLG), 32'd1);        // edge E+4, the wrap edge
    wr(A_MCR, 32'h2);               // edge E+5
    rd(ca(0, O_FLG), d);  chk("R5 set wins over clear", d, 32'd1);
    rd(ca(0, O_CUR), d);  chk("R4 cur after collide", d, exp_cur(3, 5));
    chk("R6 irq high", 32'(irq[0]), 32'd1);
    wr(ca(0, O_FLG), 32'd0);
    rd(ca(0, O_FLG), d);  chk("R5 write 0 ignored", d, 32'd1);
    wr(ca(0, O_FLG), 32'd1);
    rd(ca(0, O_FLG), d);  chk("R5 write 1 clears", d, 32'd0);
    chk("R6 irq low after clear", 32'(irq[0]), 32'd0);
    wr(ca(0, O_CTL), 32'd0);

    // R7 load write mid-count is deferred to the next wrap
    wr(A_MCR, 32'd0);
    wr(ca(2, O_LD), 32'd10);
    wr(ca(2, O_CTL), 32'h1);        // edge E
    idle(2);
    wr(ca(2, O_LD), 32'd5);         // edge E+3
    idle(9);
    wr(A_MCR, 32'h2);               // edge E+13: wrap at E+11 loads 5, then 4, 3
    rd(ca(2, O_CUR), d);  chk("R7 deferred load", d, 32'd3);
    rd(ca(2, O_FLG), d);  chk("R7 wrap flag", d, 32'd1);
    rd(ca(2, O_LD), d);   chk("R7 load readback", d, 32'd5);
    wr(ca(2, O_CTL), 32'd0);

    // R8 rewrite of run bit causes no reload; stopped channel holds
    wr(A_MCR, 32'd0);
    wr(ca(3, O_LD), 32'd20);
    wr(ca(3, O_CTL), 32'h1);        // edge E
    idle(4);
    wr(ca(3, O_CTL), 32'h1);        // edge E+5, still counting
    idle(2);
    wr(A_MCR, 32'h2);               // edge E+8
    idle(7);
    rd(ca(3, O_CUR), d);  chk("R8 no reload on rewrite / R9 frozen", d, 32'd12);
    wr(A_MCR, 32'd0);               // edge F, no step yet
    wr(ca(3, O_CTL), 32'd0);        // edge F+1 still steps once
    idle(5);
    rd(ca(3, O_CUR), d);  chk("R8 stopped hold", d, 32'd11);
    wr(ca(3, O_CUR), 32'h1234);
    rd(ca(3, O_CUR), d);  chk("R11 cur read-only", d, 32'd11);
    rd(A_MCR, d);         chk("R2 mcr readback", d, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule